// File: doc/BRIEF.md
# Multichannel Audio Slot Serializer

This block turns decoded multichannel audio samples into serial audio streams and also produces every audio clock itself. Samples arrive one per cycle as a data word, a channel index and a valid strobe. The samples collected during one frame are played out during the next frame. There are three output arrangements:

- four stereo data lines that carry two channels each;
- one eight-slot time-division line;
- a high-bitrate arrangement that spreads a single stream over all four lines.

Every slot on the wire is 32 bits wide. A sample of 16, 18, 20 or 24 bits sits at the top of its slot (left-justified) or at the bottom (right-justified). The bits of the slot that the sample does not use are zero, and the slot is sent MSB first.

The system clock `clk` runs at 512 times the sample rate, so one frame lasts 512 clock cycles, counted from the first rising edge after reset is released. The master clock runs at half the system clock, which is 256 times the sample rate. The bit clock and the word/frame select are derived from the same frame counter, so all outputs stay in a fixed phase with each other. The mode, sample width and justification inputs are sampled only at frame boundaries. Software can therefore change them at any time without breaking a frame.

Top module: `audio_slot_serializer`

## Requirements
- R1: `mclk_o` toggles on every `clk` cycle once reset is released, giving a clock at half the `clk` rate (256 times the sample rate). A frame is 512 `clk` cycles.
- R2: In stereo mode (`cfg_mode` 00 or 11) and in high-bitrate mode (10), `bclk_o` has a period of 8 `clk` cycles and is high in the second half of each bit. `lrck_o` is low for the first 32 bits of a frame (left slot) and high for the last 32 bits (right slot). `lrck_o` and `sdata_o` change only while `bclk_o` is low.
- R3: In stereo mode, line L (`sdata_o[L]`) carries channel 2L in the left slot and channel 2L+1 in the right slot, MSB first.
- R4: Width code `cfg_width` selects 16 (00), 18 (01), 20 (10) or 24 (11) bits. The sample is taken from `smp_data[w-1:0]`, and the higher input bits are ignored. With `cfg_rjust`=0 the sample fills slot bits 31..32-w and the lower slot bits are zero.
- R5: With `cfg_rjust`=1 the sample fills slot bits w-1..0 and the higher slot bits are zero.
- R6: In time-division mode (`cfg_mode` 01), `sdata_o[0]` carries slots 0 to 7 holding channels 0 to 7. Each slot is 32 bits long. `bclk_o` has a period of 2 `clk` cycles, and `sdata_o[3:1]` stay zero.
- R7: In time-division mode, `lrck_o` is a frame pulse exactly one bit clock period wide, during the last bit of the previous frame, just before slot 0.
- R8: In high-bitrate mode, `smp_chan` is ignored. The k-th accepted word of a frame (k starting at 0) goes to line k mod 4, in the left slot for k below 4 and in the right slot for k from 4 to 7. Words after the eighth in a frame are dropped.
- R9: Samples accepted during frame n are played during frame n+1. A channel that received no sample in frame n plays an all-zero slot in frame n+1. A sample written on the last cycle of a frame belongs to the following frame.
- R10: A change on `cfg_mode`, `cfg_width` or `cfg_rjust` takes effect only at the next frame boundary.
- R11: While `rst` is high, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, 512 times the sample rate |
| rst | input | 1 | Synchronous reset, active high |
| cfg_mode | input | 2 | 00/11 stereo lines, 01 time-division, 10 high-bitrate |
| cfg_width | input | 2 | Sample width code |
| cfg_rjust | input | 1 | 1 = right-justified in slot |
| smp_valid | input | 1 | Sample strobe |
| smp_chan | input | 3 | Channel index of the sample |
| smp_data | input | SAMPLE_W | Sample value, right-aligned |
| mclk_o | output | 1 | Oversampling master clock |
| bclk_o | output | 1 | Bit clock |
| lrck_o | output | 1 | Word select or frame pulse |
| sdata_o | output | 4 | Serial data lines |

## Verification
A wrong frame count or a wrong bit index shows up within one bit period. `bclk_o`, `lrck_o` or a data line then falls out of phase with a reference that counts frames on its own. A wrong staging or playback buffer, or a wrong pointer for the high-bitrate mode, leaves the clocks correct. It shows up only as wrong serial bits in the frame after the samples were written, so the reference compares every data line on every cycle. A configuration that is latched too early changes bits in the middle of a frame, before the boundary at which the change is due.

// File: rtl/audio_slot_serializer.sv
module audio_slot_serializer #(
  parameter int SAMPLE_W = 24
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [1:0]          cfg_mode,
  input  logic [1:0]          cfg_width,
  input  logic                cfg_rjust,
  input  logic                smp_valid,
  input  logic [2:0]          smp_chan,
  input  logic [SAMPLE_W-1:0] smp_data,
  output logic                mclk_o,
  output logic                bclk_o,
  output logic                lrck_o,
  output logic [3:0]          sdata_o
);
  localparam int LINES  = 4;
  localparam int CHANS  = 2 * LINES;
  localparam int SLOT_W = 32;
  localparam int FC_W   = $clog2(SLOT_W * CHANS * 2);
  localparam int IDX_W  = $clog2(CHANS);

  logic [FC_W-1:0]     fc;
  logic [SAMPLE_W-1:0] stage [CHANS];
  logic [SAMPLE_W-1:0] play  [CHANS];
  logic [CHANS-1:0]    stage_v;
  logic [IDX_W:0]      wptr;
  logic [1:0]          mode_q, width_q;
  logic                rjust_q;
  logic [LINES-1:0]    sd_n;

  wire             boundary = (fc == {FC_W{1'b1}});
  wire             tdm      = (mode_q == 2'b01);
  wire             hbr      = (mode_q == 2'b10);
  wire [IDX_W:0]   widx     = hbr ? (boundary ? '0 : wptr) : {1'b0, smp_chan};
  wire             wr_en    = smp_valid && !widx[IDX_W];
  wire [2:0]       t_slot   = fc[8:6];
  wire             half     = fc[8];
  wire [4:0]       bsel     = tdm ? fc[5:1] : fc[7:3];

  function automatic logic [SLOT_W-1:0] slot_word(input logic [SAMPLE_W-1:0] d,
                                                  input logic [1:0] wc,
                                                  input logic rj);
    logic [5:0]        w;
    logic [SLOT_W-1:0] m, x;
    case (wc)
      2'd0:    w = 6'd16;
      2'd1:    w = 6'd18;
      2'd2:    w = 6'd20;
      default: w = 6'd24;
    endcase
    m = (SLOT_W'(1) << w) - SLOT_W'(1);
    x = SLOT_W'(d) & m;
    return rj ? x : (x << (6'd32 - w));
  endfunction

  always_ff @(posedge clk) begin
    if (rst) fc <= '0;
    else     fc <= fc + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stage_v <= '0;
      wptr    <= '0;
    end else begin
      stage_v <= boundary ? '0 : stage_v;
      wptr    <= boundary ? '0 : wptr;
      if (wr_en) stage_v[widx[IDX_W-1:0]] <= 1'b1;
      if (wr_en && hbr) wptr <= widx + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) stage[widx[IDX_W-1:0]] <= smp_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < CHANS; i++) play[i] <= '0;
      mode_q  <= 2'b00;
      width_q <= 2'b11;
      rjust_q <= 1'b0;
    end else if (boundary) begin
      for (int i = 0; i < CHANS; i++) play[i] <= stage_v[i] ? stage[i] : '0;
      mode_q  <= cfg_mode;
      width_q <= cfg_width;
      rjust_q <= cfg_rjust;
    end
  end

  for (genvar l = 0; l < LINES; l++) begin : g_line
    logic [IDX_W-1:0]  ch;
    logic [SLOT_W-1:0] wd;
    assign ch = tdm ? t_slot : hbr ? {half, 2'(l)} : {2'(l), half};
    assign wd = slot_word(play[ch], width_q, rjust_q);
    if (l == 0) begin : g_main
      assign sd_n[l] = wd[5'd31 - bsel];
    end else begin : g_aux
      assign sd_n[l] = !tdm && wd[5'd31 - bsel];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mclk_o  <= 1'b0;
      bclk_o  <= 1'b0;
      lrck_o  <= 1'b0;
      sdata_o <= '0;
    end else begin
      mclk_o  <= ~fc[0];
      bclk_o  <= tdm ? fc[0] : fc[2];
      lrck_o  <= tdm ? (fc[8:1] == 8'hFF) : fc[8];
      sdata_o <= sd_n;
    end
  end
endmodule

module audio_slot_serializer_chk (
  input logic       clk,
  input logic       rst,
  input logic       mclk,
  input logic       bclk,
  input logic       lrck,
  input logic [3:0] sdata,
  input logic [1:0] mode_act
);
  AST_MCLK_TOGGLE: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> mclk != $past(mclk)); // R1
  AST_DATA_CHANGES_BCLK_LOW: assert property (@(posedge clk) disable iff (rst)
    sdata != $past(sdata) |-> !bclk); // R2
  AST_SELECT_CHANGES_BCLK_LOW: assert property (@(posedge clk) disable iff (rst)
    lrck != $past(lrck) |-> !bclk); // R2
  AST_TDM_SPARE_LINES_ZERO: assert property (@(posedge clk) disable iff (rst)
    $past(mode_act) == 2'b01 |-> sdata[3:1] == 3'b000); // R6
  AST_FSYNC_HOLDS_TWO: assert property (@(posedge clk) disable iff (rst)
    ($past(mode_act) == 2'b01 && $rose(lrck)) |=> lrck); // R7
  AST_FSYNC_ENDS: assert property (@(posedge clk) disable iff (rst)
    ($past(mode_act) == 2'b01 && lrck && $past(lrck)) |=> !lrck); // R7
endmodule

bind audio_slot_serializer audio_slot_serializer_chk u_chk (
  .clk(clk), .rst(rst), .mclk(mclk_o), .bclk(bclk_o), .lrck(lrck_o),
  .sdata(sdata_o), .mode_act(mode_q)
);

// File: tb/audio_slot_serializer_bench.sv
module audio_slot_serializer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int FRAME = 512;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  cfg_mode = 2'b00, cfg_width = 2'b11;
  logic        cfg_rjust = 1'b0, smp_valid = 1'b0;
  logic [2:0]  smp_chan = '0;
  logic [23:0] smp_data = '0;
  logic        mclk_o, bclk_o, lrck_o;
  logic [3:0]  sdata_o;

  audio_slot_serializer u_audio_slot_serializer (
    .clk(clk), .rst(rst), .cfg_mode(cfg_mode), .cfg_width(cfg_width),
    .cfg_rjust(cfg_rjust), .smp_valid(smp_valid), .smp_chan(smp_chan),
    .smp_data(smp_data), .mclk_o(mclk_o), .bclk_o(bclk_o), .lrck_o(lrck_o),
    .sdata_o(sdata_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_tests = 0, n_fail = 0;
  bit done = 0;
  string scen = "R11";

  int m_fc, m_ptr, m_mode, m_wc, m_rj;
  int st[8], pl[8];
  bit sv[8];
  bit e_mclk, e_bclk, e_ws;
  bit [3:0] e_sd;
  string e_tag = "R11", c_tag = "R11", w_tag = "R11";

  function automatic bit [31:0] slot_of(int d, int wc, int rj);
    int w = (wc == 0) ? 16 : (wc == 1) ? 18 : (wc == 2) ? 20 : 24;
    bit [31:0] x = 32'(d) & ((32'h1 << w) - 1);
    return (rj != 0) ? x : (x << (32 - w));
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_fc = 0; m_ptr = 0; m_mode = 0; m_wc = 3; m_rj = 0;
      for (int i = 0; i < 8; i++) begin st[i] = 0; pl[i] = 0; sv[i] = 0; end
      e_mclk = 0; e_bclk = 0; e_ws = 0; e_sd = 0;
      e_tag = "R11"; c_tag = "R11"; w_tag = "R11";
    end else begin
      int fc, idx, old_mode, b, ch;
      bit [31:0] wd;
      fc = m_fc; old_mode = m_mode;
      e_mclk = !fc[0];
      if (m_mode == 1) begin
        e_bclk = fc[0]; e_ws = ((fc >> 1) == 255);
        b = (fc >> 1) % 32;
        wd = slot_of(pl[fc >> 6], m_wc, m_rj);
        e_sd = {3'b000, wd[31 - b]};
        e_tag = (m_rj != 0) ? "R6 R5" : "R6 R4"; c_tag = "R6"; w_tag = "R7";
      end else begin
        e_bclk = fc[2]; e_ws = fc[8];
        b = (fc >> 3) % 32;
        for (int l = 0; l < 4; l++) begin
          ch = (m_mode == 2) ? (fc[8] * 4 + l) : (2 * l + fc[8]);
          wd = slot_of(pl[ch], m_wc, m_rj);
          e_sd[l] = wd[31 - b];
        end
        if (m_mode == 2) e_tag = (m_rj != 0) ? "R8 R5" : "R8 R4";
        else             e_tag = (m_rj != 0) ? "R3 R5" : "R3 R4";
        c_tag = "R2"; w_tag = "R2";
      end
      if (fc == FRAME - 1) begin
        for (int i = 0; i < 8; i++) begin pl[i] = sv[i] ? st[i] : 0; sv[i] = 0; end
        m_mode = cfg_mode; m_wc = cfg_width; m_rj = cfg_rjust; m_ptr = 0;
      end
      if (smp_valid) begin
        idx = (old_mode == 2) ? m_ptr : smp_chan;
        if (idx < 8) begin
          st[idx] = smp_data; sv[idx] = 1;
          if (old_mode == 2) m_ptr = idx + 1;
        end
      end
      m_fc = (fc + 1) % FRAME;
    end
  end

  task automatic chk(string tag, string what, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s [%s] %s actual %0h expected %0h at %0t", tag, scen, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      chk(rst ? "R11" : "R1", "mclk", mclk_o, e_mclk);
      chk(c_tag, "bclk", bclk_o, e_bclk);
      chk(w_tag, "lrck", lrck_o, e_ws);
      chk(e_tag, "sdata", sdata_o, e_sd);
    end
  end

  task automatic push(int ch, int d);
    smp_valid = 1; smp_chan = 3'(ch); smp_data = 24'(d);
    @(negedge clk);
    smp_valid = 0;
  endtask

  task automatic wait_frames(int n);
    repeat (n * FRAME) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    scen = "R3";
    repeat (3) @(negedge clk);
    for (int i = 0; i < 8; i++) push(i, 24'hA5C300 + i * 24'h111);
    wait_frames(2);
    scen = "R9";
    push(1, 24'h123456); push(6, 24'hFEDCBA);
    wait_frames(2);
    scen = "R5";
    cfg_rjust = 1;
    for (int wc = 0; wc < 3; wc++) begin
      cfg_width = 2'(wc);
      wait_frames(1);
      for (int i = 0; i < 8; i++) push(7 - i, 24'hFF8001 + i * 24'h3579);
      wait_frames(1);
    end
    scen = "R4";
    cfg_rjust = 0; cfg_width = 2'd1;
    wait_frames(1);
    for (int i = 0; i < 8; i++) push(i, 24'hC0FFEE ^ (i * 24'h10101));
    wait_frames(2);
    scen = "R6";
    cfg_mode = 2'b01; cfg_width = 2'd3;
    wait_frames(1);
    for (int i = 0; i < 8; i++) push(i, 24'h800001 + i * 24'h0F0F0);
    wait_frames(3);
    scen = "R8";
    cfg_mode = 2'b10;
    wait_frames(1);
    for (int i = 0; i < 10; i++) push(7, 24'h400000 + i * 24'h21);
    wait_frames(2);
    scen = "R10";
    repeat (200) @(negedge clk);
    cfg_mode = 2'b01; cfg_width = 2'd0; cfg_rjust = 1;
    for (int i = 0; i < 600; i++) push(i % 8, 24'h5A5A5A + i * 24'h1357);
    repeat (300) @(negedge clk);
    cfg_mode = 2'b00; cfg_width = 2'd2; cfg_rjust = 0;
    for (int i = 0; i < 600; i++) push((i * 3) % 8, 24'h0BEEF0 + i * 24'h2468);
    wait_frames(2);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      done = 1;
      n_tests++; n_fail++;
      $display("FAIL R11 watchdog actual running expected finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule